// File: doc/BRIEF.md
# Transmit Outcome Status and Abort Control

This block sits beside the transmit path of an Ethernet MAC and judges how each frame ended. While a frame is in flight it remembers whether the transmit FIFO ran dry. It also watches the frame length so that an oversized frame can be cut short. On the single-cycle end-of-frame strobe it compares the following:

- the collision count against the retry limit;
- the frame length against the maximum-length setting, unless huge frames are enabled;
- the deferral count against the excessive-deferral limit;
- the CRC compare result, unless the MAC inserts the CRC itself.

The results are packed into a 16-bit read-only status word.

Four outcomes are fatal: excessive collisions, underrun, jumbo and CRC error. Any of them moves the block into a halted state. In that state a registered halt output stops the descriptor write engine before its next fetch, and the transmit-error interrupt bit is raised. Both stay set until software writes one to clear the interrupt bit. A deferral is only reported and never halts.

A jumbo abort also forces the buffer-length value written back to the descriptor to zero. In every other case the length offered by the engine is passed through at the end of the frame.

The controller has three named states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No frame is in progress. |
| `ST_BUSY` | A frame is in progress. |
| `ST_HALT` | The engine is stopped after a fatal outcome. |

The transitions are:

| Transition | From | To | Condition |
|------------|------|----|-----------|
| START | `ST_IDLE` | `ST_BUSY` | `frame_start` |
| DONE_OK | `ST_BUSY` | `ST_IDLE` | `frame_end` with no fatal cause |
| DONE_FATAL | `ST_BUSY` | `ST_HALT` | `frame_end` with at least one fatal cause |
| RELEASE | `ST_HALT` | `ST_IDLE` | `err_clear` |

Top module: `tx_outcome_ctl`

## Requirements
- R1: After reset, `status_word`, `buf_len_out`, `tx_halt`, `txerr_irq` and `trunc_req` are all zero and the state is `ST_IDLE`.
- R2: At `frame_end` in `ST_BUSY`, status bit 10 (excessive collisions) is set when `coll_count` is strictly greater than `retry_limit`, and cleared otherwise.
- R3: Status bit 9 (underrun) is set at `frame_end` when `fifo_underrun` was high in any cycle of `ST_BUSY`, including the `frame_end` cycle itself.
- R4: Status bit 8 (jumbo) is set at `frame_end` when `frame_len` is greater than `max_len` and `huge_en` is 0. While in `ST_BUSY` under that same condition, `trunc_req` is high; otherwise `trunc_req` is low.
- R5: `buf_len_out` is updated at `frame_end`. It becomes zero when the jumbo bit is being set, and the value of `buf_len_in` otherwise.
- R6: Status bit 6 (deferred) is set at `frame_end` when `late_coll` is 0 and at least one of these holds: `defer_count` is at least 1 and below `defer_limit`, or `coll_defer` is 1.
- R7: Status bit 5 (CRC error) is set at `frame_end` when `crc_mismatch` is 1 and `crc_insert_en` is 0.
- R8: When `frame_end` captures any of bits 10, 9, 8 or 5, `tx_halt` and `txerr_irq` rise on the same clock edge. They then stay high until a cycle with `err_clear` high, and are low from the following edge.
- R9: Status bit 7 and bits 15:11 and 4:0 always read zero.
- R10: A `frame_start` accepted in `ST_IDLE` clears `status_word` on its edge. A `frame_start` while in `ST_HALT` is ignored, so the status and the halt are kept.
- R11: A frame whose only outcome is a deferral (bit 6) ends in `ST_IDLE` with `tx_halt` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start-of-frame strobe |
| frame_end | input | 1 | Single-cycle end-of-frame strobe |
| coll_count | input | COLL_W | Collisions seen by this frame |
| retry_limit | input | COLL_W | Configured collision retry limit |
| fifo_underrun | input | 1 | Transmit FIFO underrun strobe |
| frame_len | input | LEN_W | Current frame length |
| max_len | input | LEN_W | Maximum frame length setting |
| huge_en | input | 1 | Huge-frame support enable |
| defer_count | input | DEFER_W | Deferrals seen by this frame |
| defer_limit | input | DEFER_W | Excessive-deferral limit |
| coll_defer | input | 1 | Frame deferred because of a collision |
| late_coll | input | 1 | Late collision qualifier |
| crc_mismatch | input | 1 | Appended CRC differs from the local one |
| crc_insert_en | input | 1 | MAC inserts the CRC itself |
| err_clear | input | 1 | Write-one-to-clear of the transmit-error interrupt bit |
| buf_len_in | input | BUFLEN_W | Buffer length proposed for descriptor write-back |
| status_word | output | 16 | Packed transmit status |
| buf_len_out | output | BUFLEN_W | Buffer length to write back |
| tx_halt | output | 1 | Stop the transmit write engine |
| txerr_irq | output | 1 | Transmit-error interrupt status bit |
| trunc_req | output | 1 | Request to truncate the current frame |

## Verification
These registered outputs change on the clock edge that samples `frame_end`:

- `status_word`
- `buf_len_out`
- `tx_halt`
- `txerr_irq`

The bench therefore reads them at the falling edge one half cycle after that edge. `trunc_req` is combinational in `ST_BUSY`, so it is read at the same falling edge at which the length inputs were driven, after a short settle delay.

The release of the halt comes one edge after the `err_clear` cycle. It is checked at the falling edge that follows that rising edge, and the check one cycle earlier confirms that the halt was still held.

// File: rtl/tx_outcome_pkg.sv
package tx_outcome_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HALT = 2'd2
    } tx_state_t;

    localparam int STW        = 16;
    localparam int BIT_XCOLL  = 10;
    localparam int BIT_UNDRUN = 9;
    localparam int BIT_JUMBO  = 8;
    localparam int BIT_DEFER  = 6;
    localparam int BIT_CRC    = 5;

    typedef struct packed {
        logic xcoll;
        logic jumbo;
        logic defer;
        logic crc;
    } cause_t;

endpackage

// File: rtl/tx_outcome_eval.sv
module tx_outcome_eval #(
    parameter int COLL_W  = 5,
    parameter int LEN_W   = 14,
    parameter int DEFER_W = 4
) (
    input  logic [COLL_W-1:0]  coll_count,
    input  logic [COLL_W-1:0]  retry_limit,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic [LEN_W-1:0]   max_len,
    input  logic               huge_en,
    input  logic [DEFER_W-1:0] defer_count,
    input  logic [DEFER_W-1:0] defer_limit,
    input  logic               coll_defer,
    input  logic               late_coll,
    input  logic               crc_mismatch,
    input  logic               crc_insert_en,
    output tx_outcome_pkg::cause_t cause
);
    localparam logic [DEFER_W-1:0] ONE_DEFER = DEFER_W'(1);

    logic over_len;
    logic defer_window;

    always_comb begin
        over_len     = (frame_len > max_len);
        defer_window = (defer_count >= ONE_DEFER) && (defer_count < defer_limit);
        cause.xcoll  = (coll_count > retry_limit);
        cause.jumbo  = over_len && !huge_en;
        cause.defer  = !late_coll && (defer_window || coll_defer);
        cause.crc    = crc_mismatch && !crc_insert_en;
    end
endmodule

// File: rtl/tx_outcome_fsm.sv
module tx_outcome_fsm
    import tx_outcome_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic      frame_end,
    input  logic      fatal,
    input  logic      err_clear,
    output tx_state_t state,
    output logic      start_take,
    output logic      end_take,
    output logic      halted
);
    tx_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        start_take = 1'b0;
        end_take   = 1'b0;
        halted     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (frame_start) begin
                    start_take = 1'b1;
                    state_nx   = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (frame_end) begin
                    end_take = 1'b1;
                    state_nx = fatal ? ST_HALT : ST_IDLE;
                end
            end
            ST_HALT: begin
                halted = 1'b1;
                if (err_clear) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/tx_outcome_ctl.sv
module tx_outcome_ctl
    import tx_outcome_pkg::*;
#(
    parameter int COLL_W   = 5,
    parameter int LEN_W    = 14,
    parameter int DEFER_W  = 4,
    parameter int BUFLEN_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                frame_end,
    input  logic [COLL_W-1:0]   coll_count,
    input  logic [COLL_W-1:0]   retry_limit,
    input  logic                fifo_underrun,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [LEN_W-1:0]    max_len,
    input  logic                huge_en,
    input  logic [DEFER_W-1:0]  defer_count,
    input  logic [DEFER_W-1:0]  defer_limit,
    input  logic                coll_defer,
    input  logic                late_coll,
    input  logic                crc_mismatch,
    input  logic                crc_insert_en,
    input  logic                err_clear,
    input  logic [BUFLEN_W-1:0] buf_len_in,
    output logic [STW-1:0]      status_word,
    output logic [BUFLEN_W-1:0] buf_len_out,
    output logic                tx_halt,
    output logic                txerr_irq,
    output logic                trunc_req
);
    cause_t    cause;
    tx_state_t state;
    logic      start_take, end_take, halted;
    logic      undrun_seen, undrun_now, fatal;
    logic [STW-1:0] status_nx;

    tx_outcome_eval #(
        .COLL_W (COLL_W),
        .LEN_W  (LEN_W),
        .DEFER_W(DEFER_W)
    ) u_eval (
        .coll_count   (coll_count),
        .retry_limit  (retry_limit),
        .frame_len    (frame_len),
        .max_len      (max_len),
        .huge_en      (huge_en),
        .defer_count  (defer_count),
        .defer_limit  (defer_limit),
        .coll_defer   (coll_defer),
        .late_coll    (late_coll),
        .crc_mismatch (crc_mismatch),
        .crc_insert_en(crc_insert_en),
        .cause        (cause)
    );

    tx_outcome_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .fatal      (fatal),
        .err_clear  (err_clear),
        .state      (state),
        .start_take (start_take),
        .end_take   (end_take),
        .halted     (halted)
    );

    always_comb begin
        undrun_now = undrun_seen || fifo_underrun;
        fatal      = cause.xcoll || cause.jumbo || cause.crc || undrun_now;
        status_nx              = '0;
        status_nx[BIT_XCOLL]   = cause.xcoll;
        status_nx[BIT_UNDRUN]  = undrun_now;
        status_nx[BIT_JUMBO]   = cause.jumbo;
        status_nx[BIT_DEFER]   = cause.defer;
        status_nx[BIT_CRC]     = cause.crc;
        tx_halt   = halted;
        txerr_irq = halted;
        trunc_req = (state == ST_BUSY) && cause.jumbo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            undrun_seen <= 1'b0;
        end else if (start_take || end_take) begin
            undrun_seen <= 1'b0;
        end else if (state == ST_BUSY && fifo_underrun) begin
            undrun_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_word <= '0;
            buf_len_out <= '0;
        end else if (start_take) begin
            status_word <= '0;
        end else if (end_take) begin
            status_word <= status_nx;
            buf_len_out <= cause.jumbo ? '0 : buf_len_in;
        end
    end
endmodule

// File: rtl/tx_outcome_chk.sv
module tx_outcome_chk #(
    parameter int LEN_W    = 14,
    parameter int BUFLEN_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_end,
    input logic                err_clear,
    input logic [LEN_W-1:0]    frame_len,
    input logic [LEN_W-1:0]    max_len,
    input logic                huge_en,
    input logic [15:0]         status_word,
    input logic [BUFLEN_W-1:0] buf_len_out,
    input logic                tx_halt,
    input logic                txerr_irq,
    input logic                trunc_req
);
    assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[15:11] == 5'd0) && !status_word[7] && (status_word[4:0] == 5'd0));

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halt && !err_clear) |=> tx_halt);

    assert_halt_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halt && err_clear) |=> !tx_halt);

    assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> ($past(frame_end) &&
            (status_word[10] || status_word[9] || status_word[8] || status_word[5])));

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txerr_irq == tx_halt);

    assert_jumbo_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[8]) |-> (buf_len_out == '0));

    assert_trunc_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_req |-> (!huge_en && (frame_len > max_len)));
endmodule

bind tx_outcome_ctl tx_outcome_chk #(
    .LEN_W   (LEN_W),
    .BUFLEN_W(BUFLEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .err_clear  (err_clear),
    .frame_len  (frame_len),
    .max_len    (max_len),
    .huge_en    (huge_en),
    .status_word(status_word),
    .buf_len_out(buf_len_out),
    .tx_halt    (tx_halt),
    .txerr_irq  (txerr_irq),
    .trunc_req  (trunc_req)
);

// File: tb/tx_outcome_ctl_tb.sv
module tx_outcome_ctl_tb;
    localparam int CW = 5;
    localparam int LW = 14;
    localparam int DW = 4;
    localparam int BW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, frame_end = 0, fifo_underrun = 0;
    logic [CW-1:0] coll_count = '0, retry_limit = '0;
    logic [LW-1:0] frame_len = '0, max_len = '0;
    logic huge_en = 0, coll_defer = 0, late_coll = 0;
    logic [DW-1:0] defer_count = '0, defer_limit = '0;
    logic crc_mismatch = 0, crc_insert_en = 0, err_clear = 0;
    logic [BW-1:0] buf_len_in = '0;
    logic [15:0] status_word;
    logic [BW-1:0] buf_len_out;
    logic tx_halt, txerr_irq, trunc_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tx_outcome_ctl #(.COLL_W(CW), .LEN_W(LW), .DEFER_W(DW), .BUFLEN_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .coll_count(coll_count), .retry_limit(retry_limit), .fifo_underrun(fifo_underrun),
        .frame_len(frame_len), .max_len(max_len), .huge_en(huge_en),
        .defer_count(defer_count), .defer_limit(defer_limit), .coll_defer(coll_defer),
        .late_coll(late_coll), .crc_mismatch(crc_mismatch), .crc_insert_en(crc_insert_en),
        .err_clear(err_clear), .buf_len_in(buf_len_in), .status_word(status_word),
        .buf_len_out(buf_len_out), .tx_halt(tx_halt), .txerr_irq(txerr_irq),
        .trunc_req(trunc_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Runs one frame; und_mode 0 none, 1 pulse mid-frame, 2 pulse in end cycle.
    task automatic run_frame(input string req, input int und_mode, input int blen);
        int exp_st;
        logic exp_fatal;
        logic jumbo;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check({req, " R10 cleared at start"}, int'(status_word), 0);
        fifo_underrun = (und_mode == 1);
        buf_len_in = BW'(blen);
        jumbo = (frame_len > max_len) && !huge_en;
        #1;
        check({req, " R4 trunc_req"}, int'(trunc_req), int'(jumbo));
        @(negedge clk);
        fifo_underrun = (und_mode == 2);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        fifo_underrun = 1'b0;
        exp_st = 0;
        if (coll_count > retry_limit) exp_st |= (1 << 10);
        if (und_mode != 0) exp_st |= (1 << 9);
        if (jumbo) exp_st |= (1 << 8);
        if (!late_coll && (((defer_count >= 1) && (defer_count < defer_limit)) || coll_defer))
            exp_st |= (1 << 6);
        if (crc_mismatch && !crc_insert_en) exp_st |= (1 << 5);
        exp_fatal = (exp_st & 32'h720) != 0;
        check({req, " R2 R3 R4 R6 R7 R9 status"}, int'(status_word), exp_st);
        check({req, " R5 buf_len_out"}, int'(buf_len_out), jumbo ? 0 : blen);
        check({req, " R8 R11 tx_halt"}, int'(tx_halt), int'(exp_fatal));
        check({req, " R8 txerr_irq"}, int'(txerr_irq), int'(exp_fatal));
        if (exp_fatal) begin
            @(negedge clk);
            check({req, " R8 halt held"}, int'(tx_halt), 1);
            err_clear = 1'b1;
            @(negedge clk);
            err_clear = 1'b0;
            check({req, " R8 halt released"}, int'(tx_halt), 0);
            check({req, " R8 irq released"}, int'(txerr_irq), 0);
        end
    endtask

    task automatic set_neutral();
        coll_count = '0; retry_limit = CW'(4);
        frame_len = LW'(64); max_len = LW'(1518); huge_en = 1'b0;
        defer_count = '0; defer_limit = DW'(8); coll_defer = 1'b0; late_coll = 1'b0;
        crc_mismatch = 1'b0; crc_insert_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_neutral();
        repeat (3) @(negedge clk);
        check("R1 status", int'(status_word), 0);
        check("R1 buf_len_out", int'(buf_len_out), 0);
        check("R1 tx_halt", int'(tx_halt), 0);
        check("R1 txerr_irq", int'(txerr_irq), 0);
        check("R1 trunc_req", int'(trunc_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 sweep of collision count around the limit
        for (int c = 0; c < 10; c++) begin
            set_neutral();
            coll_count = CW'(c);
            run_frame("R2", 0, 100 + c);
        end
        // R3 underrun in mid-frame and in the end cycle
        for (int u = 0; u < 3; u++) begin
            set_neutral();
            run_frame("R3", u, 200);
        end
        // R4 R5 length against maximum with huge enable
        for (int h = 0; h < 2; h++) begin
            for (int l = 0; l < 4; l++) begin
                set_neutral();
                huge_en = h[0];
                frame_len = (l == 0) ? LW'(100) : (l == 1) ? LW'(1518) :
                            (l == 2) ? LW'(1519) : LW'(9000);
                run_frame("R4 R5", 0, 1500 + l);
            end
        end
        // R6 R11 deferral sweep
        for (int dl = 0; dl < 3; dl++) begin
            for (int d = 0; d < 8; d++) begin
                for (int q = 0; q < 4; q++) begin
                    set_neutral();
                    defer_limit = (dl == 0) ? DW'(0) : (dl == 1) ? DW'(3) : DW'(7);
                    defer_count = DW'(d);
                    coll_defer = q[0];
                    late_coll = q[1];
                    run_frame("R6 R11", 0, 300);
                end
            end
        end
        // R7 CRC compare gated by insert enable
        for (int m = 0; m < 4; m++) begin
            set_neutral();
            crc_mismatch = m[0];
            crc_insert_en = m[1];
            run_frame("R7", 0, 400);
        end
        // R8 several causes together
        set_neutral();
        coll_count = CW'(9); crc_mismatch = 1'b1; frame_len = LW'(2000);
        run_frame("R8 combined", 1, 500);

        // R10 start ignored while halted
        set_neutral();
        crc_mismatch = 1'b1;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
        check("R10 halted", int'(tx_halt), 1);
        frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        check("R10 status kept while halted", int'(status_word), 32'h20);
        check("R10 halt kept", int'(tx_halt), 1);
        frame_end = 1'b1;
        crc_mismatch = 1'b0;
        @(negedge clk); frame_end = 1'b0;
        check("R10 end ignored while halted", int'(status_word), 32'h20);
        err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
        check("R8 release after R10", int'(tx_halt), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule